// File: doc/BRIEF.md
# Shadow-Buffered Calendar Clock

The block keeps wall-clock time (seconds, minutes, hour, day of week, day of month, month and a two-digit year counted from 2000) and advances it on a one-cycle `tick` pulse that arrives once per second. Host software reaches it through a small byte-wide register bus. It never touches the running counter directly. Time bytes written by software are held in a shadow bank. A write-commit request moves them into the live counter after a selectable transfer delay. A read-capture request copies the live time into a read buffer after the same delay, so that seven separate byte reads give one coherent time.

A control register selects plain binary or packed BCD byte encoding, and 24-hour or 12-hour presentation of the hour. The encoding is applied when bytes are decoded at commit and when they are encoded at capture. Inside the block the counter always runs in binary 24-hour form. Each request bit in the update register stays set while its transfer is in flight and clears itself when the transfer ends, so software polls that register to learn when a transfer has finished.

Top module: `rtc_shadow_cal`

## Requirements
- R1: After reset the live time is 00:00:00, Sunday, day 1, month 1, year 0. The control register reads 0x02 (binary, 24-hour), the update register reads 0x00 and every read-buffer byte reads 0x00.
- R2: Addresses 0 to 6 hold the time bytes in this order: seconds, minutes, hour, weekday, date, month, year. Address 8 is control (bit 0 BCD, bit 1 24-hour). Address 9 is update (bit 0 write-commit, bit 1 read-capture, bit 2 time-enable, bit 4 short delay). Writes to addresses 0 to 6 reach only the shadow bank, and reads of those addresses return the read buffer, so neither the readable bytes nor the live time change.
- R3: Writing update bit 0 together with bit 2 loads the decoded shadow time into the live counter after the transfer delay. Bits 0 and 2 read as 1 for exactly that many cycles and then clear. A tick in the completing cycle is dropped in favour of the loaded value.
- R4: A write-commit request made without bit 2 completes and clears bit 0 but leaves the live time unchanged.
- R5: A read-capture request (bit 1) copies the encoded live time into the read buffer when its delay ends. Bit 1 reads 1 until then. The buffer then holds its value while the counter keeps running.
- R6: Update bit 4 selects the delay of the request made in the same write: LAT_LONG cycles (default 40) when it is 0, LAT_SHORT cycles (default 6) when it is 1. Bit 4 reads back as last written.
- R7: A request on a channel that is already busy is ignored. It neither restarts the delay nor changes the captured time-enable.
- R8: Each tick advances seconds, carrying into minutes, hours and the day. The weekday byte is one-hot with bit 0 for Sunday through bit 6 for Saturday, and Saturday advances to Sunday.
- R9: Day of month wraps after the month's length: 30 for April, June, September and November, 29 for February when the year is a multiple of 4, 28 for February otherwise, and 31 for the other months. December 31 of year 99 advances to January 1 of year 0.
- R10: With the BCD bit set, every numeric byte is written and read as two decimal digits per byte (tens in bits 7:4). With the bit clear, bytes are plain binary.
- R11: In 12-hour mode the hour byte holds 1 to 12 in bits 4:0 and a PM flag in bit 6. Hour 0 reads as 12 without PM, 12 reads as 12 with PM, and 13 reads as 1 with PM.
- R12: Committed values out of range are replaced: seconds or minutes above 59 and hours above 23 become 0, year above 99 becomes 0, month 0 or above 12 becomes 1, a date of 0 or past the month's length becomes 1, and a weekday byte with no bit among 6:0 set becomes Sunday.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |

## Verification
On every cycle the assertions check the following properties of the counter and the update channels. The live fields stay inside their calendar ranges, and seconds step by one on a plain tick. A load overrides a coinciding tick, and a commit without time-enable leaves the counter alone. A busy channel ends only from a zero count and counts straight through a repeated request. The read buffer changes only on a capture. The encoding paths can only be shown by the bench's scenarios. These cover the BCD and 12-hour byte layouts, month length and leap years at rollover, clamping of bad committed bytes, the exact delay seen at the register port, and the fact that shadow writes stay invisible until a commit.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

   localparam int NUM_TIME_REGS = 7;
   localparam int IX_SEC  = 0;
   localparam int IX_MIN  = 1;
   localparam int IX_HOUR = 2;
   localparam int IX_WDAY = 3;
   localparam int IX_DATE = 4;
   localparam int IX_MON  = 5;
   localparam int IX_YEAR = 6;

   // live calendar, always binary and 24-hour
   typedef struct packed {
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hour;
      logic [2:0] wday;   // 0 = Sunday
      logic [4:0] date;   // 1..31
      logic [3:0] mon;    // 1..12
      logic [6:0] year;   // 0..99
   } cal_t;

   localparam cal_t CAL_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0, wday: 3'd0,
                                  date: 5'd1, mon: 4'd1, year: 7'd0};

   function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
      logic [3:0] t;
      logic [3:0] u;
      t = 4'(v / 7'd10);
      u = 4'(v % 7'd10);
      return {t, u};
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
      logic [6:0] t;
      t = {3'b000, b[7:4]};
      return (t * 7'd10) + {3'b000, b[3:0]};
   endfunction

   function automatic logic [7:0] enc_num(input logic [6:0] v, input logic bcd);
      return bcd ? bin_to_bcd(v) : {1'b0, v};
   endfunction

   function automatic logic [6:0] dec_num(input logic [7:0] b, input logic bcd);
      return bcd ? bcd_to_bin(b) : b[6:0];
   endfunction

   function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic [6:0] year);
      case (mon)
         4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                 return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
`timescale 1ns/1ps
module rtc_cal_counter
   import rtc_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   input  cal_t load_val,
   output cal_t now
);

   cal_t nxt;

   always_comb begin
      nxt = now;
      if (now.sec >= 6'd59) begin
         nxt.sec = 6'd0;
         if (now.min >= 6'd59) begin
            nxt.min = 6'd0;
            if (now.hour >= 5'd23) begin
               nxt.hour = 5'd0;
               nxt.wday = (now.wday >= 3'd6) ? 3'd0 : now.wday + 3'd1;
               if (now.date >= days_in_month(now.mon, now.year)) begin
                  nxt.date = 5'd1;
                  if (now.mon >= 4'd12) begin
                     nxt.mon  = 4'd1;
                     nxt.year = (now.year >= 7'd99) ? 7'd0 : now.year + 7'd1;
                  end else begin
                     nxt.mon = now.mon + 4'd1;
                  end
               end else begin
                  nxt.date = now.date + 5'd1;
               end
            end else begin
               nxt.hour = now.hour + 5'd1;
            end
         end else begin
            nxt.min = now.min + 6'd1;
         end
      end else begin
         nxt.sec = now.sec + 6'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    now <= CAL_RESET;
      else if (load) now <= load_val;
      else if (tick) now <= nxt;
   end

   // R3
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (now == $past(load_val)));

   // R8
   sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && now.sec != 6'd59) |=> (now.sec == $past(now.sec) + 6'd1));

   // R8
   field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (now.sec < 6'd60) && (now.min < 6'd60) && (now.hour < 5'd24) && (now.wday < 3'd7));

   // R9
   date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (now.date != 5'd0) && (now.date <= days_in_month(now.mon, now.year)) &&
      (now.mon != 4'd0) && (now.mon <= 4'd12) && (now.year <= 7'd99));

endmodule

// File: rtl/rtc_cal_codec.sv
`timescale 1ns/1ps
module rtc_cal_codec
   import rtc_cal_pkg::*;
#(
   parameter bit BCD_SUPPORT = 1'b1
) (
   input  logic                           bcd_mode,
   input  logic                           h24_mode,
   input  cal_t                           live,
   input  logic [NUM_TIME_REGS-1:0][7:0]  shadow,
   output logic [NUM_TIME_REGS-1:0][7:0]  enc,
   output cal_t                           dec
);

   logic bcd_eff;

   if (BCD_SUPPORT) begin : g_bcd
      assign bcd_eff = bcd_mode;
   end else begin : g_bin_only
      assign bcd_eff = 1'b0;
   end

   // live -> register bytes
   logic       pm;
   logic [4:0] h12;

   always_comb begin
      pm = (live.hour >= 5'd12);
      if (live.hour == 5'd0)       h12 = 5'd12;
      else if (live.hour > 5'd12)  h12 = live.hour - 5'd12;
      else                         h12 = live.hour;

      enc[IX_SEC]  = enc_num({1'b0, live.sec}, bcd_eff);
      enc[IX_MIN]  = enc_num({1'b0, live.min}, bcd_eff);
      enc[IX_HOUR] = h24_mode ? enc_num({2'b00, live.hour}, bcd_eff)
                              : (enc_num({2'b00, h12}, bcd_eff) | {1'b0, pm, 6'b000000});
      enc[IX_WDAY] = 8'd1 << live.wday;
      enc[IX_DATE] = enc_num({2'b00, live.date}, bcd_eff);
      enc[IX_MON]  = enc_num({3'b000, live.mon}, bcd_eff);
      enc[IX_YEAR] = enc_num(live.year, bcd_eff);
   end

   // shadow bytes -> clamped live fields
   logic [6:0] d_sec, d_min, d_hr, h_raw, d_date, d_mon, d_year;
   logic [3:0] wd_idx;
   logic [4:0] dim;

   always_comb begin
      d_sec = dec_num(shadow[IX_SEC] & 8'h7f, bcd_eff);
      d_min = dec_num(shadow[IX_MIN] & 8'h7f, bcd_eff);
      h_raw = dec_num(shadow[IX_HOUR] & (bcd_eff ? 8'h1f : 8'h0f), bcd_eff);
      if (h24_mode)
         d_hr = dec_num(shadow[IX_HOUR] & 8'h3f, bcd_eff);
      else
         d_hr = ((h_raw == 7'd12) ? 7'd0 : h_raw) + (shadow[IX_HOUR][6] ? 7'd12 : 7'd0);
      d_date = dec_num(shadow[IX_DATE] & (bcd_eff ? 8'h3f : 8'h1f), bcd_eff);
      d_mon  = dec_num(shadow[IX_MON]  & (bcd_eff ? 8'h1f : 8'h0f), bcd_eff);
      d_year = dec_num(bcd_eff ? shadow[IX_YEAR] : (shadow[IX_YEAR] & 8'h7f), bcd_eff);

      wd_idx = 4'd0;
      for (int b = 7; b >= 0; b--) begin
         if (shadow[IX_WDAY][b]) wd_idx = 4'(b);
      end

      dec.sec  = (d_sec  > 7'd59) ? 6'd0 : d_sec[5:0];
      dec.min  = (d_min  > 7'd59) ? 6'd0 : d_min[5:0];
      dec.hour = (d_hr   > 7'd23) ? 5'd0 : d_hr[4:0];
      dec.wday = (wd_idx > 4'd6)  ? 3'd0 : wd_idx[2:0];
      dec.mon  = (d_mon == 7'd0 || d_mon > 7'd12) ? 4'd1 : d_mon[3:0];
      dec.year = (d_year > 7'd99) ? 7'd0 : d_year;
      dim      = days_in_month(dec.mon, dec.year);
      dec.date = (d_date == 7'd0 || d_date > {2'b00, dim}) ? 5'd1 : d_date[4:0];
   end

endmodule

// File: rtl/rtc_cal_upd_chan.sv
`timescale 1ns/1ps
module rtc_cal_upd_chan #(
   parameter int LAT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAT_W-1:0] lat_cycles,
   output logic             busy,
   output logic             done
);

   logic [LAT_W-1:0] cnt;

   assign done = busy && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= lat_cycles - LAT_W'(1);
         end
      end else if (cnt == '0) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt - LAT_W'(1);
      end
   end

   // R3
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == '0));

   // R7
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cnt != '0) |=> (busy && (cnt == $past(cnt) - LAT_W'(1))));

endmodule

// File: rtl/rtc_shadow_cal.sv
`timescale 1ns/1ps
module rtc_shadow_cal
   import rtc_cal_pkg::*;
#(
   parameter int LAT_LONG    = 40,
   parameter int LAT_SHORT   = 6,
   parameter bit BCD_SUPPORT = 1'b1,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);

   localparam int LAT_W     = $clog2(LAT_LONG + 1);
   localparam int NUM_CHAN  = 2;
   localparam int CH_WRITE  = 0;
   localparam int CH_READ   = 1;
   localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] ADDR_UPD  = ADDR_W'(9);
   localparam logic [ADDR_W-1:0] ADDR_NT   = ADDR_W'(NUM_TIME_REGS);

   if (LAT_SHORT < 1 || LAT_SHORT >= LAT_LONG) begin : g_bad_lat
      $error("rtc_shadow_cal: need 1 <= LAT_SHORT < LAT_LONG");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("rtc_shadow_cal: ADDR_W must be at least 4");
   end

   logic                                bus_we;
   logic [NUM_TIME_REGS-1:0][7:0]       shadow;
   logic [NUM_TIME_REGS-1:0][7:0]       rbuf;
   logic [NUM_TIME_REGS-1:0][7:0]       enc;
   logic                                bcd_mode, h24_mode, lat_sel, te_hold;
   logic [LAT_W-1:0]                    lat_pick;
   logic [NUM_CHAN-1:0]                 ch_start, ch_busy, ch_done;
   logic                                load;
   cal_t                                live, dec;

   assign bus_we   = bus_sel && bus_wr;
   assign lat_pick = bus_wdata[4] ? LAT_W'(LAT_SHORT) : LAT_W'(LAT_LONG);
   assign ch_start[CH_WRITE] = bus_we && (bus_addr == ADDR_UPD) && bus_wdata[0];
   assign ch_start[CH_READ]  = bus_we && (bus_addr == ADDR_UPD) && bus_wdata[1];
   assign load = ch_done[CH_WRITE] && te_hold;

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      rtc_cal_upd_chan #(.LAT_W(LAT_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .start      (ch_start[c]),
         .lat_cycles (lat_pick),
         .busy       (ch_busy[c]),
         .done       (ch_done[c])
      );
   end

   rtc_cal_codec #(.BCD_SUPPORT(BCD_SUPPORT)) u_codec (
      .bcd_mode (bcd_mode),
      .h24_mode (h24_mode),
      .live     (live),
      .shadow   (shadow),
      .enc      (enc),
      .dec      (dec)
   );

   rtc_cal_counter u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load),
      .load_val (dec),
      .now      (live)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow   <= '0;
         rbuf     <= '0;
         bcd_mode <= 1'b0;
         h24_mode <= 1'b1;
         lat_sel  <= 1'b0;
         te_hold  <= 1'b0;
      end else begin
         if (bus_we && bus_addr < ADDR_NT)
            shadow[bus_addr[2:0]] <= bus_wdata;
         if (bus_we && bus_addr == ADDR_CTRL) begin
            bcd_mode <= bus_wdata[0];
            h24_mode <= bus_wdata[1];
         end
         if (bus_we && bus_addr == ADDR_UPD)
            lat_sel <= bus_wdata[4];
         if (ch_start[CH_WRITE] && !ch_busy[CH_WRITE])
            te_hold <= bus_wdata[2];
         else if (ch_done[CH_WRITE])
            te_hold <= 1'b0;
         if (ch_done[CH_READ])
            rbuf <= enc;
      end
   end

   always_comb begin
      if (bus_addr < ADDR_NT)
         bus_rdata = rbuf[bus_addr[2:0]];
      else if (bus_addr == ADDR_CTRL)
         bus_rdata = {6'b000000, h24_mode, bcd_mode};
      else if (bus_addr == ADDR_UPD)
         bus_rdata = {3'b000, lat_sel, 1'b0, te_hold && ch_busy[CH_WRITE],
                      ch_busy[CH_READ], ch_busy[CH_WRITE]};
      else
         bus_rdata = 8'h00;
   end

   // R5
   rbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_done[CH_READ] |=> $stable(rbuf));

   // R4
   no_te_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_done[CH_WRITE] && !te_hold && !tick) |=> $stable(live));

endmodule

// File: tb/rtc_shadow_cal_tb.sv
`timescale 1ns/1ps
module rtc_shadow_cal_tb;

   localparam int LAT_LONG  = 40;
   localparam int LAT_SHORT = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = 4'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rtc_shadow_cal #(.LAT_LONG(LAT_LONG), .LAT_SHORT(LAT_SHORT)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   typedef struct {
      logic [3:0] addr;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t sb_q[$];

   // monitor: pops one expected item per cycle and compares
   always @(negedge clk) begin : monitor
      item_t it;
      #1;
      if (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         n_chk++;
         if (bus_rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s addr %0d actual 0x%02h expected 0x%02h", it.tag, it.addr, bus_rdata, it.exp);
         end
      end
   end

   task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      @(negedge clk);
      bus_addr = a;
      sb_q.push_back('{addr: a, exp: e, tag: tag});
   endtask

   task automatic check_val(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wait_idle(input int b);
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         bus_addr = 4'd9;
         #1;
         if (!bus_rdata[b]) break;
      end
   endtask

   // counts cycles with write-commit busy, right after the request write
   task automatic busy_cycles(output int n, output logic [7:0] first);
      bus_addr = 4'd9;
      #1;
      first = bus_rdata;
      n = 0;
      while (bus_rdata[0] && n < 1000) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   task automatic load_shadow(input logic [7:0] s, m, h, w, d, mo, y);
      bus_write(4'd0, s);  bus_write(4'd1, m);  bus_write(4'd2, h);
      bus_write(4'd3, w);  bus_write(4'd4, d);  bus_write(4'd5, mo);
      bus_write(4'd6, y);
   endtask

   task automatic commit(input logic [7:0] s, m, h, w, d, mo, y);
      load_shadow(s, m, h, w, d, mo, y);
      bus_write(4'd9, 8'h15);
      wait_idle(0);
   endtask

   task automatic snap();
      bus_write(4'd9, 8'h12);
      wait_idle(1);
   endtask

   task automatic exp_time(input logic [7:0] s, m, h, w, d, mo, y, input string tag);
      expect_rd(4'd0, s, tag);  expect_rd(4'd1, m, tag);  expect_rd(4'd2, h, tag);
      expect_rd(4'd3, w, tag);  expect_rd(4'd4, d, tag);  expect_rd(4'd5, mo, tag);
      expect_rd(4'd6, y, tag);
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin : driver
      int         n;
      logic [7:0] first;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 7; a++) expect_rd(4'(a), 8'h00, "R1 rbuf reset");
      expect_rd(4'd8, 8'h02, "R1 ctrl reset");
      expect_rd(4'd9, 8'h00, "R1 upd reset");
      snap();
      exp_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 live reset");

      // R2 shadow writes stay invisible
      load_shadow(8'h11, 8'h12, 8'h03, 8'h08, 8'h09, 8'h02, 8'h05);
      expect_rd(4'd0, 8'h00, "R2 read buffer untouched");
      expect_rd(4'd3, 8'h01, "R2 read buffer untouched");
      snap();
      exp_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R2 live untouched");

      // R3 + R6 long commit, 10:20:30 Tue 15/6/24
      load_shadow(8'd30, 8'd20, 8'd10, 8'h04, 8'd15, 8'd6, 8'd24);
      bus_write(4'd9, 8'h05);
      busy_cycles(n, first);
      check_val(int'(first), 8'h05, "R3 busy and time-enable bits");
      check_val(n, LAT_LONG, "R6 long delay");
      expect_rd(4'd9, 8'h00, "R3 bits cleared");
      snap();
      exp_time(8'd30, 8'd20, 8'd10, 8'h04, 8'd15, 8'd6, 8'd24, "R3 committed time");

      // R6 short commit of same shadow
      bus_write(4'd9, 8'h15);
      busy_cycles(n, first);
      check_val(int'(first), 8'h15, "R6 short request readback");
      check_val(n, LAT_SHORT, "R6 short delay");
      expect_rd(4'd9, 8'h10, "R6 select bit held");

      // R4 commit without time-enable
      bus_write(4'd0, 8'd5);
      bus_write(4'd2, 8'd1);
      bus_write(4'd9, 8'h11);
      wait_idle(0);
      expect_rd(4'd9, 8'h10, "R4 bit cleared");
      snap();
      exp_time(8'd30, 8'd20, 8'd10, 8'h04, 8'd15, 8'd6, 8'd24, "R4 time unchanged");

      // R5 snapshot stays stable while counting
      tick_n(3);
      expect_rd(4'd0, 8'd30, "R5 buffer stable");
      snap();
      expect_rd(4'd0, 8'd33, "R5 new capture");

      // R7 second request while busy is ignored
      load_shadow(8'd0, 8'd45, 8'd7, 8'h10, 8'd10, 8'd11, 8'd50);
      bus_write(4'd9, 8'h15);
      bus_write(4'd9, 8'h11);
      wait_idle(0);
      snap();
      exp_time(8'd0, 8'd45, 8'd7, 8'h10, 8'd10, 8'd11, 8'd50, "R7 first request kept");

      // R8 R9 R10 BCD full rollover, Saturday 31/12/99 23:59:59
      bus_write(4'd8, 8'h03);
      commit(8'h59, 8'h59, 8'h23, 8'h40, 8'h31, 8'h12, 8'h99);
      tick_n(1);
      snap();
      expect_rd(4'd0, 8'h00, "R10 bcd sec");
      expect_rd(4'd1, 8'h00, "R10 bcd min");
      expect_rd(4'd2, 8'h00, "R8 hour wrap");
      expect_rd(4'd3, 8'h01, "R8 saturday to sunday");
      expect_rd(4'd4, 8'h01, "R9 date wrap");
      expect_rd(4'd5, 8'h01, "R9 month wrap");
      expect_rd(4'd6, 8'h00, "R9 year wrap");

      // R10 binary loaded, read as BCD
      bus_write(4'd8, 8'h02);
      commit(8'd45, 8'd30, 8'd19, 8'h08, 8'd15, 8'd6, 8'd24);
      bus_write(4'd8, 8'h03);
      snap();
      exp_time(8'h45, 8'h30, 8'h19, 8'h08, 8'h15, 8'h06, 8'h24, "R10 bcd encode");
      bus_write(4'd8, 8'h02);

      // R9 month lengths and leap years (binary)
      commit(8'd59, 8'd59, 8'd23, 8'h01, 8'd28, 8'd2, 8'd1);
      tick_n(1); snap();
      exp_time(8'd0, 8'd0, 8'd0, 8'h02, 8'd1, 8'd3, 8'd1, "R9 feb 28 common year");
      commit(8'd59, 8'd59, 8'd23, 8'h01, 8'd28, 8'd2, 8'd4);
      tick_n(1); snap();
      expect_rd(4'd4, 8'd29, "R9 feb 29 leap year");
      expect_rd(4'd5, 8'd2, "R9 feb 29 leap year");
      commit(8'd59, 8'd59, 8'd23, 8'h01, 8'd29, 8'd2, 8'd4);
      tick_n(1); snap();
      expect_rd(4'd4, 8'd1, "R9 leap feb end");
      expect_rd(4'd5, 8'd3, "R9 leap feb end");
      commit(8'd59, 8'd59, 8'd23, 8'h20, 8'd30, 8'd4, 8'd24);
      tick_n(1); snap();
      exp_time(8'd0, 8'd0, 8'd0, 8'h40, 8'd1, 8'd5, 8'd24, "R9 april end");

      // R11 12-hour mode
      commit(8'd0, 8'd5, 8'd13, 8'h01, 8'd1, 8'd1, 8'd0);
      bus_write(4'd8, 8'h00);
      snap();
      expect_rd(4'd2, 8'h41, "R11 13h as 1 PM");
      commit(8'd0, 8'd5, 8'h0C, 8'h01, 8'd1, 8'd1, 8'd0);
      snap();
      expect_rd(4'd2, 8'h0C, "R11 midnight as 12 AM");
      bus_write(4'd8, 8'h02);
      snap();
      expect_rd(4'd2, 8'h00, "R11 12 AM is hour 0");

      // R12 clamping of bad committed bytes
      commit(8'h7F, 8'd5, 8'd30, 8'h00, 8'd31, 8'd4, 8'd120);
      snap();
      exp_time(8'd0, 8'd5, 8'd0, 8'h01, 8'd1, 8'd4, 8'd0, "R12 clamp");

      repeat (3) @(negedge clk);
      report();
   end

endmodule